// File: doc/BRIEF.md
# Cascadable Dual 8-Bit Interval Timer

This block has two identical 8-bit timer channels. Each channel has a counter, a compare register, an enable bit and a mode register. When a channel is enabled, it counts ticks from one of several single-cycle tick sources, which its mode register selects. When its count equals its compare value, the counter goes back to zero and the channel sends a one-cycle interrupt pulse. The counter then keeps running, so the interrupts repeat at a fixed interval.

A cascade bit in the upper channel's mode register joins the two channels into one 16-bit interval timer. The lower channel's counter is the low byte and the upper channel's counter is the high byte. Only the lower channel's tick selection drives the count. The pair clears when both halves match at the same time, and that full match raises the lower channel's interrupt. The upper channel still raises its own interrupt when a carry moves its count onto its compare value. Software reaches every register through a simple write/read port, and it can also read back both counters.

Top module: `casc_itimer`

## Requirements
- R1: After an asynchronous reset, every register reads 0x00: mode, compare, enable and counter of both channels. Both interrupt outputs are low.
- R2: Address bit 2 selects the channel (0 = lower, 1 = upper). Address bits [1:0] select the field: 0 = mode, 1 = compare, 2 = enable (bit 0), 3 = counter (read only). A mode write is read back unchanged. Mode bits [1:0] select the tick source, and mode bit 4 of the upper channel turns on cascade.
- R3: When cascade is off, each enabled channel counts only the `tick_i` line that its own mode bits [1:0] index. The two channels are independent.
- R4: A channel runs in clear-and-start mode. On a tick where its count equals its compare value (any value from 0x00 to 0xFF), the counter becomes 0x00. The channel's interrupt is high for exactly the one cycle that follows that tick, so the interval is compare + 1 ticks.
- R5: In cascade mode the counters form a 16-bit count with the upper channel as the high byte. The lower counter wraps from 0xFF to 0x00 and carries one into the upper counter. When the 16-bit count equals {upper compare, lower compare}, both counters clear and `irq_o[0]` pulses.
- R6: In cascade mode a full 16-bit match takes priority over the lower counter's carry. When the lower compare is 0xFF, the upper counter therefore stays at its compare value and does not advance.
- R7: In cascade mode the count advances only on the tick line that the lower channel's mode selects. The upper channel's tick selection has no effect.
- R8: In cascade mode `irq_o[1]` pulses for one cycle after a carry that moves the upper count onto the upper compare value. No full 16-bit match is needed for this pulse.
- R9: In cascade mode, once the upper enable is set, writing only the lower enable stops the whole 16-bit count (write 0) or clears both counters and restarts the count (write 1).
- R10: A compare write is ignored while that channel's enable is set.
- R11: Clearing an enable holds the counter at its current value. Setting the enable again from 0 clears the counter to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | NUM_SRC (4) | Single-cycle count tick sources |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address {channel, field} |
| wr_data_i | input | CNT_W (8) | Write data |
| rd_addr_i | input | 3 | Read address {channel, field} |
| rd_data_o | output | CNT_W (8) | Read data (combinational) |
| irq_o | output | 2 | Interrupt pulses, bit 0 lower, bit 1 upper |

## Verification
The hardest states to reach are two cascade cases. One is the moment where a lower-byte carry and a full 16-bit match fall on the same tick. The other is a carry that lands the upper count on its own compare value. The stimulus reaches both by choosing compare pairs such as 0x00FF and 0x0103 and then driving runs of several hundred ticks, long enough to cross several wrap periods. A directed sequence then stops the 16-bit count in the middle of a run through the lower enable alone and resumes it. This checks that the held value survives the stop and that both bytes clear on restart.

// File: rtl/casc_itimer_pkg.sv
package casc_itimer_pkg;
  localparam int unsigned CNT_W_DEF = 8;
  localparam int unsigned NUM_SRC_DEF = 4;
  localparam int unsigned CASC_BIT = 4;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [1:0] {
    FLD_MODE = 2'd0,
    FLD_CMP  = 2'd1,
    FLD_EN   = 2'd2,
    FLD_CNT  = 2'd3
  } fld_e;

  typedef struct packed {
    logic clr;
    logic inc;
    logic hit;
  } step_t;
endpackage

// File: rtl/casc_itimer_chan.sv
module casc_itimer_chan
  import casc_itimer_pkg::*;
#(
  parameter int unsigned W = CNT_W_DEF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  step_t        step_i,
  output logic [W-1:0] cnt_o,
  output logic         irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= step_i.hit;
      if (step_i.clr)      cnt_o <= '0;
      else if (step_i.inc) cnt_o <= cnt_o + W'(1);
    end
  end
endmodule

// File: rtl/casc_itimer_regs.sv
module casc_itimer_regs
  import casc_itimer_pkg::*;
#(
  parameter int unsigned W = CNT_W_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [W-1:0]        wr_data_i,
  output logic [1:0][W-1:0]   mode_o,
  output logic [1:0][W-1:0]   cmp_o,
  output logic [1:0]          en_o,
  output logic [1:0]          en_set_o
);
  fld_e fld;
  assign fld = fld_e'(wr_addr_i[1:0]);

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (wr_addr_i[2] == 1'(g));
    // rising enable write restarts the count from zero
    assign en_set_o[g] = sel && (fld == FLD_EN) && wr_data_i[0] && !en_o[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_o[g] <= '0;
        cmp_o[g]  <= '0;
        en_o[g]   <= 1'b0;
      end else if (sel) begin
        case (fld)
          FLD_MODE: mode_o[g] <= wr_data_i;
          FLD_CMP:  if (!en_o[g]) cmp_o[g] <= wr_data_i;
          FLD_EN:   en_o[g] <= wr_data_i[0];
          default:  ;
        endcase
      end
    end
  end
endmodule

// File: rtl/casc_itimer.sv
module casc_itimer
  import casc_itimer_pkg::*;
#(
  parameter int unsigned CNT_W   = CNT_W_DEF,
  parameter int unsigned NUM_SRC = NUM_SRC_DEF
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_SRC-1:0]  tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [CNT_W-1:0]    rd_data_o,
  output logic [1:0]          irq_o
);
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0][CNT_W-1:0] mode_q, cmp_q;
  logic [1:0]            en_q, en_set;
  logic [CNT_W-1:0]      cnt_q [2];
  step_t                 step [2];

  casc_itimer_regs #(.W(CNT_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i),
    .mode_o   (mode_q),
    .cmp_o    (cmp_q),
    .en_o     (en_q),
    .en_set_o (en_set)
  );

  logic [SEL_W-1:0] sel0, sel1;
  logic casc, t0, t1, m0, m1, full, lo_top, carry, hi_land;

  assign sel0    = mode_q[0][SEL_W-1:0];
  assign sel1    = mode_q[1][SEL_W-1:0];
  assign casc    = mode_q[1][CASC_BIT];
  assign t0      = en_q[0] && tick_i[sel0];
  assign t1      = en_q[1] && tick_i[sel1];
  assign m0      = (cnt_q[0] == cmp_q[0]);
  assign m1      = (cnt_q[1] == cmp_q[1]);
  assign full    = m0 && m1;
  assign lo_top  = &cnt_q[0];
  // full match wins over the low-byte carry
  assign carry   = t0 && !full && lo_top && en_q[1];
  assign hi_land = ((cnt_q[1] + CNT_W'(1)) == cmp_q[1]);

  always_comb begin
    if (casc) begin
      step[0].clr = en_set[0] || (t0 && full);
      step[0].inc = t0 && !full;
      step[0].hit = t0 && full;
      step[1].clr = en_set[1] || en_set[0] || (t0 && full);
      step[1].inc = carry;
      step[1].hit = carry && hi_land;
    end else begin
      step[0].clr = en_set[0] || (t0 && m0);
      step[0].inc = t0 && !m0;
      step[0].hit = t0 && m0;
      step[1].clr = en_set[1] || (t1 && m1);
      step[1].inc = t1 && !m1;
      step[1].hit = t1 && m1;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    casc_itimer_chan #(.W(CNT_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .step_i(step[g]),
      .cnt_o (cnt_q[g]),
      .irq_o (irq_o[g])
    );
  end

  always_comb begin
    case (fld_e'(rd_addr_i[1:0]))
      FLD_MODE: rd_data_o = mode_q[rd_addr_i[2]];
      FLD_CMP:  rd_data_o = cmp_q[rd_addr_i[2]];
      FLD_EN:   rd_data_o = CNT_W'(en_q[rd_addr_i[2]]);
      default:  rd_data_o = cnt_q[rd_addr_i[2]];
    endcase
  end
endmodule

// File: rtl/casc_itimer_chk.sv
module casc_itimer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [1:0]   irq_i,
  input logic [W-1:0] cnt0_i,
  input logic [W-1:0] cnt1_i,
  input logic [W-1:0] cmp0_i,
  input logic [W-1:0] cmp1_i,
  input logic [1:0]   en_i,
  input logic         casc_i,
  input logic         wr_en_i,
  input logic [2:0]   wr_addr_i,
  input logic         wr_d0_i
);
  // R4
  lo_irq_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[0] |-> cnt0_i == '0);

  // R5
  full_match_clears_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[0] && $past(casc_i) |-> cnt1_i == '0);

  // R8
  hi_irq_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[1] && $past(casc_i) |-> cnt1_i == cmp1_i);

  // R4
  hi_irq_solo_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i[1] && !$past(casc_i) |-> cnt1_i == '0);

  // R10
  cmp_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[0] |=> cmp0_i == $past(cmp0_i));

  // R10
  cmp_hi_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i[1] |=> cmp1_i == $past(cmp1_i));

  // R11
  stopped_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i[0] && !(wr_en_i && wr_addr_i == 3'd2 && wr_d0_i) |=> $stable(cnt0_i));
endmodule

bind casc_itimer casc_itimer_chk #(.W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_i    (irq_o),
  .cnt0_i   (cnt_q[0]),
  .cnt1_i   (cnt_q[1]),
  .cmp0_i   (cmp_q[0]),
  .cmp1_i   (cmp_q[1]),
  .en_i     (en_q),
  .casc_i   (casc),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_d0_i  (wr_data_i[0])
);

// File: tb/casc_itimer_tb_top.sv
module casc_itimer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;

  typedef struct packed {
    logic        casc;
    logic [1:0]  sel0;
    logic [1:0]  sel1;
    logic [7:0]  cmp0;
    logic [7:0]  cmp1;
    logic [3:0]  mask;
    logic [15:0] n;
    logic [15:0] e_irq0;
    logic [15:0] e_irq1;
    logic [7:0]  e_c0;
    logic [7:0]  e_c1;
  } vec_t;

  // casc sel0 sel1 cmp0 cmp1 mask ticks irq0 irq1 cnt0 cnt1
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd1, 2'd2, 8'h04, 8'h02, 4'b0110, 16'd13,  16'd2, 16'd4,  8'd3,  8'd1},
    '{1'b0, 2'd0, 2'd3, 8'h00, 8'hFF, 4'b0001, 16'd5,   16'd5, 16'd0,  8'd0,  8'd0},
    '{1'b0, 2'd2, 2'd2, 8'hFF, 8'h07, 4'b0100, 16'd300, 16'd1, 16'd37, 8'd44, 8'd4},
    '{1'b1, 2'd1, 2'd0, 8'h03, 8'h01, 4'b0010, 16'd600, 16'd2, 16'd2,  8'd80, 8'd0},
    '{1'b1, 2'd3, 2'd0, 8'h00, 8'h00, 4'b1000, 16'd7,   16'd7, 16'd0,  8'd0,  8'd0},
    '{1'b1, 2'd0, 2'd0, 8'hFF, 8'h00, 4'b0001, 16'd520, 16'd2, 16'd0,  8'd8,  8'd0},
    '{1'b1, 2'd0, 2'd1, 8'h10, 8'h00, 4'b0010, 16'd50,  16'd0, 16'd0,  8'd0,  8'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tick = '0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] irq;

  int checks = 0;
  int fails = 0;
  int irq_cnt0 = 0;
  int irq_cnt1 = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  casc_itimer dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data),
    .irq_o    (irq)
  );

  always @(negedge clk) begin
    if (irq[0]) irq_cnt0++;
    if (irq[1]) irq_cnt1++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic run_ticks(input logic [3:0] m, input int n);
    @(negedge clk);
    tick = m;
    repeat (n) @(negedge clk);
    tick = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic setup(input logic c, input logic [1:0] s0, input logic [1:0] s1,
                       input logic [7:0] p0, input logic [7:0] p1);
    wr(3'd2, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd4, {3'b000, c, 2'b00, s1});
    wr(3'd0, {6'b0, s0});
    wr(3'd1, p0);
    wr(3'd5, p1);
    wr(3'd6, 8'h01);
    wr(3'd2, 8'h01);
  endtask

  initial begin
    logic [7:0] d;
    int b0, b1;
    vec_t t;
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 reg after reset", int'(d), 0);
    end
    check("R1 irq after reset", int'(irq), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      t = VECS[v];
      setup(t.casc, t.sel0, t.sel1, t.cmp0, t.cmp1);
      @(negedge clk); #1;
      b0 = irq_cnt0; b1 = irq_cnt1;
      run_ticks(t.mask, int'(t.n));
      #1;
      // R3 R4 solo; R5 R6 R7 R8 cascade
      check(t.casc ? "R5 R6 R7 lo irq count" : "R3 R4 lo irq count", irq_cnt0 - b0, int'(t.e_irq0));
      check(t.casc ? "R8 hi irq count" : "R3 R4 hi irq count", irq_cnt1 - b1, int'(t.e_irq1));
      rd(3'd3, d);
      check(t.casc ? "R5 R7 lo count" : "R3 R4 lo count", int'(d), int'(t.e_c0));
      rd(3'd7, d);
      check(t.casc ? "R5 R6 hi count" : "R3 R4 hi count", int'(d), int'(t.e_c1));
    end

    // R2 mode readback
    rd(3'd4, d);
    check("R2 upper mode readback", int'(d), 8'h11);

    // R10 compare writes while running
    setup(1'b0, 2'd0, 2'd0, 8'h20, 8'h30);
    wr(3'd1, 8'h77);
    rd(3'd1, d);
    check("R10 cmp write ignored while enabled", int'(d), 8'h20);
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h77);
    rd(3'd1, d);
    check("R10 cmp write taken while stopped", int'(d), 8'h77);

    // R9 R11 cascade stop/restart via lower enable
    setup(1'b1, 2'd1, 2'd0, 8'h03, 8'h01);
    run_ticks(4'b0010, 258);
    rd(3'd3, d); check("R5 lo byte mid run", int'(d), 2);
    rd(3'd7, d); check("R5 hi byte mid run", int'(d), 1);
    wr(3'd2, 8'h00);
    run_ticks(4'b0010, 5);
    rd(3'd3, d); check("R11 lo held while stopped", int'(d), 2);
    rd(3'd7, d); check("R9 hi held while lower stopped", int'(d), 1);
    wr(3'd2, 8'h01);
    rd(3'd3, d); check("R9 R11 lo cleared on restart", int'(d), 0);
    rd(3'd7, d); check("R9 hi cleared on restart", int'(d), 0);
    run_ticks(4'b0010, 3);
    rd(3'd3, d); check("R9 lo resumes from zero", int'(d), 3);
    rd(3'd7, d); check("R9 hi resumes from zero", int'(d), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule